// File: doc/BRIEF.md
# Row-to-Column Print Image Transposer

This block turns one print line, delivered as a buffer of row-oriented words, into a stream of per-column codes. The buffer holds 24 words of 36 bits. Each pair of words makes one of twelve card-style rows, and the two words of a pair cover the left and right halves of a 72-column line. After a start strobe the block reads every word once, in ascending order, and ORs its bits into a column register. It tells the buffer owner to clear each word as it is consumed. It then streams the column codes from column 0 onward.

Streaming stops at the last column that holds any set bit, so trailing blank columns are never emitted. In text mode each beat carries the raw 12-bit row pattern and a nonzero flag. In binary mode the code is suppressed and only a mark/blank flag is given per column. Turning a code into a printable character is left to the consumer.

Top module: `row_col_transposer`

## Requirements
- R1: After synchronous reset, `col_valid_o` and `clr_o` are low until a start is accepted.
- R2: A start accepted while idle is followed, from the next cycle, by 24 consecutive load cycles. In these cycles `rd_addr_o` steps 0,1,…,23 with `clr_o` high, and `rd_data_i` is sampled combinationally in the same cycle. The buffer owner clears the addressed word at that clock edge.
- R3: Word index i sets row bit i/2 (bit 0 = word pair 0, bit 11 = word pair 11) of the column codes it touches.
- R4: Even-indexed words map to columns 0–35 and odd-indexed words to columns 36–71. Bit 35 of a word lands in the first column of its half and bit 0 in the last.
- R5: The first stream beat appears in the cycle after the final load cycle, with `col_idx_o` = 0. Indices then rise by one per cycle without gaps.
- R6: The beat whose index is the highest column holding a set bit carries `col_last_o`, and `col_valid_o` drops in the next cycle. A line with no set bit emits column 0 alone, flagged last.
- R7: In binary mode (`bin_mode_i` = 1 at the accepted start), each beat has `col_code_o` = 0 and `col_mark_o` = 1 exactly when the column has any row bit set. The mode is held for the whole line.
- R8: In text mode (`bin_mode_i` = 0 at the accepted start), `col_code_o` is the full 12-bit row pattern of the column and `col_mark_o` is high exactly when that pattern is nonzero.
- R9: A start during loading or streaming is ignored. The current line's beats are unchanged, and no new load cycles follow.
- R10: Each line's codes depend only on the words read for that line. Nothing carries over from earlier lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a line (accepted only when idle) |
| bin_mode_i | input | 1 | 1 = binary mark/blank mode, 0 = text code mode; sampled at start |
| rd_addr_o | output | 5 | Word buffer read address |
| rd_data_i | input | 36 | Word buffer read data, combinational from `rd_addr_o` |
| clr_o | output | 1 | Clear the addressed word at this clock edge |
| col_valid_o | output | 1 | Column beat valid |
| col_last_o | output | 1 | Final beat of the line |
| col_idx_o | output | 7 | Column number of the beat |
| col_code_o | output | 12 | Row pattern of the column (zero in binary mode) |
| col_mark_o | output | 1 | Column has at least one row bit set |

## Verification
The lines fed to the block are:
- fully random buffers, which exercise the whole row and column mapping;
- buffers with only even words filled, which end the line inside the left half and test trimming;
- an all-zero buffer, for the single-beat case;
- single set bits at column 0 row 0, column 71 row 11, and a mid-line odd-word bit, which pin down the bit order and the half selection.

Each pattern runs in both modes, so that code suppression and mark derivation are told apart. Start pulses injected during loading and during streaming must leave the line intact. A fresh line after a dense one must show no residue from it.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    typedef enum logic [1:0] {
        XP_IDLE   = 2'd0,
        XP_LOAD   = 2'd1,
        XP_STREAM = 2'd2
    } xp_state_e;

    // Half of the line (0 = left, 1 = right) that a column belongs to.
    function automatic int half_of(input int col, input int wbits);
        return col / wbits;
    endfunction

    // Bit of a row word that feeds a given column: first column takes the MSB.
    function automatic int bitpos_of(input int col, input int wbits);
        return wbits - 1 - (col % wbits);
    endfunction

endpackage

// File: rtl/xp_ctrl.sv
module xp_ctrl
    import xpose_pkg::*;
#(
    parameter int N_WORDS = 24,
    parameter int N_COLS  = 72,
    parameter int AW      = 5,
    parameter int CW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          bin_mode_i,
    input  logic [CW-1:0] last_col_i,
    output logic          clr_cols_o,
    output logic          ld_en_o,
    output logic [AW-1:0] ld_idx_o,
    output logic          st_en_o,
    output logic [CW-1:0] col_idx_o,
    output logic          last_o,
    output logic          bin_q_o
);
    localparam int CNT_W = (AW > CW) ? AW : CW;

    xp_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             load_done;
    logic             at_last;

    assign load_done = (cnt == CNT_W'(N_WORDS - 1));
    assign at_last   = (cnt[CW-1:0] == last_col_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= XP_IDLE;
            cnt     <= '0;
            bin_q_o <= 1'b0;
        end else begin
            unique case (state)
                XP_IDLE: begin
                    if (start_i) begin
                        state   <= XP_LOAD;
                        cnt     <= '0;
                        bin_q_o <= bin_mode_i;
                    end
                end
                XP_LOAD: begin
                    if (load_done) begin
                        state <= XP_STREAM;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                XP_STREAM: begin
                    if (at_last) begin
                        state <= XP_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= XP_IDLE;
            endcase
        end
    end

    assign clr_cols_o = (state == XP_IDLE) && start_i;
    assign ld_en_o    = (state == XP_LOAD);
    assign ld_idx_o   = cnt[AW-1:0];
    assign st_en_o    = (state == XP_STREAM);
    assign col_idx_o  = cnt[CW-1:0];
    assign last_o     = (state == XP_STREAM) && at_last;

    if (N_COLS < 2) begin : g_bad_cols
        initial $error("xp_ctrl: N_COLS too small");
    end
endmodule

// File: rtl/xp_lastfind.sv
module xp_lastfind #(
    parameter int N_COLS = 72,
    parameter int CW     = 7
) (
    input  logic [N_COLS-1:0] nz_i,
    output logic [CW-1:0]     last_o
);
    always_comb begin
        last_o = '0;
        for (int c = 0; c < N_COLS; c++) begin
            if (nz_i[c]) last_o = CW'(c);
        end
    end
endmodule

// File: rtl/xp_accum.sv
module xp_accum
    import xpose_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ROW_W  = 12,
    parameter int N_COLS = 72,
    parameter int AW     = 5,
    parameter int CW     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              ld_en_i,
    input  logic [AW-1:0]     ld_idx_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [CW-1:0]     rd_col_i,
    output logic [ROW_W-1:0]  code_o,
    output logic [N_COLS-1:0] nz_o
);
    logic [ROW_W-1:0] cols [N_COLS];
    logic [AW-2:0]    row_sel;

    assign row_sel = ld_idx_i[AW-1:1];

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        localparam int HALF = half_of(c, WORD_W);
        localparam int BITP = bitpos_of(c, WORD_W);

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                cols[c] <= '0;
            end else if (ld_en_i && (ld_idx_i[0] == 1'(HALF))) begin
                cols[c] <= cols[c] | (ROW_W'(data_i[BITP]) << row_sel);
            end
        end

        assign nz_o[c] = |cols[c];
    end

    assign code_o = cols[rd_col_i];
endmodule

// File: rtl/row_col_transposer.sv
module row_col_transposer
    import xpose_pkg::*;
#(
    parameter int N_WORDS = 24,
    parameter int WORD_W  = 36,
    localparam int ROW_W  = N_WORDS / 2,
    localparam int N_COLS = 2 * WORD_W,
    localparam int AW     = $clog2(N_WORDS),
    localparam int CW     = $clog2(N_COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bin_mode_i,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              clr_o,
    output logic              col_valid_o,
    output logic              col_last_o,
    output logic [CW-1:0]     col_idx_o,
    output logic [ROW_W-1:0]  col_code_o,
    output logic              col_mark_o
);
    logic              clr_cols;
    logic              ld_en;
    logic [AW-1:0]     ld_idx;
    logic              st_en;
    logic [CW-1:0]     st_idx;
    logic              st_last;
    logic              bin_q;
    logic [CW-1:0]     last_col;
    logic [ROW_W-1:0]  code_raw;
    logic [N_COLS-1:0] col_nz;

    xp_ctrl #(
        .N_WORDS(N_WORDS), .N_COLS(N_COLS), .AW(AW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .bin_mode_i(bin_mode_i),
        .last_col_i(last_col), .clr_cols_o(clr_cols), .ld_en_o(ld_en),
        .ld_idx_o(ld_idx), .st_en_o(st_en), .col_idx_o(st_idx),
        .last_o(st_last), .bin_q_o(bin_q)
    );

    xp_accum #(
        .WORD_W(WORD_W), .ROW_W(ROW_W), .N_COLS(N_COLS), .AW(AW), .CW(CW)
    ) u_accum (
        .clk(clk), .rst(rst), .clr_i(clr_cols), .ld_en_i(ld_en),
        .ld_idx_i(ld_idx), .data_i(rd_data_i), .rd_col_i(st_idx),
        .code_o(code_raw), .nz_o(col_nz)
    );

    xp_lastfind #(
        .N_COLS(N_COLS), .CW(CW)
    ) u_last (
        .nz_i(col_nz), .last_o(last_col)
    );

    assign rd_addr_o   = ld_en ? ld_idx : '0;
    assign clr_o       = ld_en;
    assign col_valid_o = st_en;
    assign col_last_o  = st_last;
    assign col_idx_o   = st_en ? st_idx : '0;
    assign col_code_o  = (st_en && !bin_q) ? code_raw : '0;
    assign col_mark_o  = st_en && (|code_raw);
endmodule

// File: rtl/xpose_chk.sv
module xpose_chk #(
    parameter int N_WORDS = 24,
    parameter int AW      = 5,
    parameter int CW      = 7,
    parameter int ROW_W   = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [AW-1:0]    rd_addr_o,
    input logic             clr_o,
    input logic             col_valid_o,
    input logic             col_last_o,
    input logic [CW-1:0]    col_idx_o,
    input logic [ROW_W-1:0] col_code_o,
    input logic             col_mark_o,
    input logic             bin_q
);
    // R1: outputs stay quiet while reset is applied
    always @(negedge clk) if (rst) p_reset_quiet_r1: assert (!col_valid_o && !clr_o);

    // R2: load addresses start at zero and step by one
    p_addr_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_o) |-> rd_addr_o == '0);
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_o && rd_addr_o != AW'(N_WORDS - 1)) |=> (clr_o && rd_addr_o == $past(rd_addr_o) + AW'(1)));

    // R5: streaming follows the final load at column 0, then steps by one
    p_stream_follows_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_o && rd_addr_o == AW'(N_WORDS - 1)) |=> (col_valid_o && col_idx_o == '0));
    p_col_step_r5: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && !col_last_o) |=> (col_valid_o && col_idx_o == $past(col_idx_o) + CW'(1)));

    // R6: last beat ends the stream
    p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
        col_last_o |=> !col_valid_o);
    p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
        col_last_o |-> col_valid_o);

    // R7: binary mode suppresses the code
    p_bin_code_r7: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && bin_q) |-> col_code_o == '0);

    // R8: text mode flag tracks the code
    p_text_mark_r8: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && !bin_q) |-> (col_mark_o == (col_code_o != '0)));

    // R9: start while streaming does not begin a load
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && start_i) |=> !clr_o);
endmodule

bind row_col_transposer xpose_chk #(
    .N_WORDS(N_WORDS), .AW(AW), .CW(CW), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_addr_o(rd_addr_o),
    .clr_o(clr_o), .col_valid_o(col_valid_o), .col_last_o(col_last_o),
    .col_idx_o(col_idx_o), .col_code_o(col_code_o), .col_mark_o(col_mark_o),
    .bin_q(bin_q)
);

// File: tb/row_col_transposer_tb.sv
module row_col_transposer_tb;
    localparam int NW = 24;
    localparam int WW = 36;
    localparam int NC = 72;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          bin_mode_i = 1'b0;
    logic [4:0]    rd_addr_o;
    logic [WW-1:0] rd_data_i;
    logic          clr_o;
    logic          col_valid_o, col_last_o, col_mark_o;
    logic [6:0]    col_idx_o;
    logic [RW-1:0] col_code_o;

    logic [WW-1:0] mem [NW];
    int            exp_code [NC];
    int            exp_last;
    int            n_checks = 0;
    int            n_err = 0;

    always #5 clk = ~clk;

    row_col_transposer u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .bin_mode_i(bin_mode_i),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .clr_o(clr_o),
        .col_valid_o(col_valid_o), .col_last_o(col_last_o),
        .col_idx_o(col_idx_o), .col_code_o(col_code_o), .col_mark_o(col_mark_o)
    );

    assign rd_data_i = mem[rd_addr_o];
    always @(posedge clk) if (clr_o) mem[rd_addr_o] <= '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Expected column image from the mapping rules (R3, R4) and trim rule (R6)
    task automatic compute_expected();
        for (int c = 0; c < NC; c++) exp_code[c] = 0;
        for (int w = 0; w < NW; w++)
            for (int b = 0; b < WW; b++)
                if (mem[w][b]) exp_code[(w % 2) * WW + (WW - 1 - b)] |= (1 << (w / 2));
        exp_last = 0;
        for (int c = 0; c < NC; c++) if (exp_code[c] != 0) exp_last = c;
    endtask

    task automatic fill(input int kind);
        for (int w = 0; w < NW; w++) mem[w] = '0;
        case (kind)
            0: for (int w = 0; w < NW; w++) mem[w] = {$urandom(), $urandom()};
            1: for (int w = 0; w < NW; w += 2) mem[w] = {$urandom(), $urandom()} & {{4{1'b1}}, {32{$urandom_range(0,1) == 1}}};
            2: ;
            3: mem[23][0] = 1'b1;
            4: mem[0][35] = 1'b1;
            5: mem[7][20] = 1'b1;
            default: ;
        endcase
    endtask

    task automatic run_line(input logic bin, input bit poke_load, input bit poke_stream);
        int j;
        compute_expected();
        bin_mode_i = bin;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        bin_mode_i = ~bin;   // mode must be latched (R7)
        for (int k = 0; k < NW; k++) begin
            if (poke_load && k == 5) start_i = 1'b1;
            if (poke_load && k == 6) start_i = 1'b0;
            chk(clr_o === 1'b1, "R2", "clr during load", clr_o, 1);
            chk(rd_addr_o == 5'(k), "R2", "load address", rd_addr_o, k);
            @(negedge clk);
        end
        start_i = 1'b0;
        j = 0;
        forever begin
            if (poke_stream && j == 0) start_i = 1'b1;
            if (j == 1) start_i = 1'b0;
            chk(col_valid_o === 1'b1, "R5", "beat valid", col_valid_o, 1);
            chk(col_idx_o == 7'(j), "R5", "beat index", col_idx_o, j);
            if (bin) begin
                chk(col_code_o == '0, "R7", "binary code", col_code_o, 0);
                chk(col_mark_o == (exp_code[j] != 0), "R7", "binary mark", col_mark_o, exp_code[j] != 0);
            end else begin
                chk(int'(col_code_o) == exp_code[j], "R8", "column code (R3/R4)", col_code_o, exp_code[j]);
                chk(col_mark_o == (exp_code[j] != 0), "R8", "text mark", col_mark_o, exp_code[j] != 0);
            end
            chk(col_last_o == (j == exp_last), "R6", "last flag", col_last_o, j == exp_last);
            @(negedge clk);
            if (j >= exp_last || j >= NC - 1) break;
            j++;
        end
        start_i = 1'b0;
        chk(col_valid_o === 1'b0, "R6", "valid after last", col_valid_o, 0);
        for (int k = 0; k < 3; k++) begin
            chk(clr_o === 1'b0, "R9", "no load after ignored start", clr_o, 0);
            @(negedge clk);
        end
        for (int w = 0; w < NW; w++)
            chk(mem[w] == '0, "R2", "word cleared", int'(mem[w][31:0]), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C01));
        for (int w = 0; w < NW; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        chk(col_valid_o === 1'b0 && clr_o === 1'b0, "R1", "quiet in reset", col_valid_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(col_valid_o === 1'b0 && clr_o === 1'b0, "R1", "quiet after reset", clr_o, 0);

        fill(3); run_line(1'b0, 0, 0);   // R3 R4: column 71 row 11
        fill(4); run_line(1'b0, 0, 0);   // R4: column 0 row 0
        fill(5); run_line(1'b0, 0, 0);   // R4: odd word mid-line
        fill(2); run_line(1'b0, 0, 0);   // R6: all blank
        fill(2); run_line(1'b1, 0, 0);
        for (int n = 0; n < 6; n++) begin
            fill(0); run_line(n[0], n == 2, n == 3);   // R9 pokes
            fill(1); run_line(n[1], 0, n == 4);        // R10: follows dense line
        end
        fill(3); run_line(1'b1, 1, 1);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule